// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by counting a 12-bit value down at a rate taken from a slow tick input. A 3-bit select divides that tick by a power of two before each decrement. Software must refresh the counter by issuing a reload command carrying a fixed key. The refresh must arrive inside a window: the counter must already have fallen to or below a programmed delta threshold.

A refresh that arrives too early raises a reset request. So does a counter that is allowed to run past zero. Either way the request is a single-cycle pulse, and the counter restarts from the programmed reload value.

The reload value, the delta threshold and the rate select sit behind a write lock. The lock is engaged after reset and is released only by a fixed unlock key. A debug-halt input freezes the count and the divider while it is high. Every pin is a plain strobe or level. There is no streaming data path, so there is no valid/ready handshake and no back-pressure to manage.

Top module: `wdog_window`

## Requirements
- R1: After reset, count_o reads 12'hFFF, rst_req_o is low, the reload value and the delta threshold are both 12'hFFF, the rate select is 0, and the configuration lock is engaged.
- R2: With rate select 0, every cycle with tick_i high and dbg_halt_i low decrements count_o by one in the following cycle.
- R3: With rate select S (a 3-bit value), the counter decrements once per 2^S accepted ticks. Ticks are counted from the last accepted rate-select write or the last valid reload command.
- R4: An accepted decrement while count_o is 0 produces a one-cycle rst_req_o pulse in the next cycle. In that same cycle count_o equals the reload value.
- R5: kick_i with kick_key_i equal to 16'h7E81, while count_o is at or below the delta threshold, loads the reload value into count_o in the next cycle and leaves rst_req_o low.
- R6: kick_i with kick_key_i equal to 16'h7E81, while count_o is above the delta threshold, produces an rst_req_o pulse in the next cycle, with count_o loaded with the reload value.
- R7: kick_i with any other key value has no effect on count_o or on rst_req_o.
- R8: While dbg_halt_i is high, ticks are ignored and count_o holds its value.
- R9: While the lock is engaged, writes to the reload value, the delta threshold and the rate select are ignored. A lock write of 16'hC3A5 releases the lock. A lock write of any other value engages it.
- R10: A new reload value does not change count_o until the next reload, whether that reload comes from a valid kick or from a reset event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow time-base tick, one cycle wide |
| dbg_halt_i | input | 1 | Freezes counting while high |
| rld_we_i | input | 1 | Write strobe for the reload value |
| rld_val_i | input | 12 | Reload value |
| dlt_we_i | input | 1 | Write strobe for the delta threshold |
| dlt_val_i | input | 12 | Delta threshold |
| psc_we_i | input | 1 | Write strobe for the rate select |
| psc_val_i | input | 3 | Rate select (divide by 2^value) |
| lock_we_i | input | 1 | Write strobe for the lock key |
| lock_key_i | input | 16 | Lock key; 16'hC3A5 unlocks, any other value locks |
| kick_i | input | 1 | Reload command strobe |
| kick_key_i | input | 16 | Key that accompanies the reload command |
| count_o | output | 12 | Current counter value |
| rst_req_o | output | 1 | One-cycle reset request pulse |

## Verification
All results land one clock after the edge at which their stimulus is sampled. A decrement, a reload, a reset pulse and an accepted configuration write each take effect at that next edge. A configuration write first shows up through the counter at the next reload.

The bench drives inputs on the falling edge and samples outputs on the following falling edge, so every result is read exactly one edge after its stimulus. A behavioural model, updated on each rising edge from the same inputs, is compared against count_o and rst_req_o on every cycle. Directed checks add explicit expected values at the window boundary, at underflow and at the lock transitions.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hC3A5;
  localparam logic [KEY_W-1:0] KICK_KEY   = 16'h7E81;

  typedef enum logic [2:0] {
    EV_IDLE,
    EV_DEC,
    EV_UNDER,
    EV_KICK,
    EV_EARLY
  } wdog_ev_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] sel_i,
  output logic             stb_o
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             tick_ok;

  assign mask    = ~({DIV_W{1'b1}} << sel_i);
  assign tick_ok = tick_i && !halt_i;
  assign stb_o   = tick_ok && (div_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (clr_i || stb_o) begin
      div_q <= '0;
    end else if (tick_ok) begin
      div_q <= div_q + 1'b1;
    end
  end

  // R3: the divider never runs past the selected terminal count
  p_div_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((div_q & ~mask) == '0) || $changed(sel_i));
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg #(
  parameter int CNT_W = 12,
  parameter int PSC_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rld_we_i,
  input  logic [CNT_W-1:0]          rld_val_i,
  input  logic                      dlt_we_i,
  input  logic [CNT_W-1:0]          dlt_val_i,
  input  logic                      psc_we_i,
  input  logic [PSC_W-1:0]          psc_val_i,
  input  logic                      lock_we_i,
  input  logic [wdog_pkg::KEY_W-1:0] lock_key_i,
  output logic [CNT_W-1:0]          reload_o,
  output logic [CNT_W-1:0]          delta_o,
  output logic [PSC_W-1:0]          psc_o,
  output logic                      psc_wr_o
);
  import wdog_pkg::*;

  logic locked_q;

  assign psc_wr_o = psc_we_i && !locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
      reload_o <= {CNT_W{1'b1}};
      delta_o  <= {CNT_W{1'b1}};
      psc_o    <= '0;
    end else begin
      if (rld_we_i && !locked_q) reload_o <= rld_val_i;
      if (dlt_we_i && !locked_q) delta_o  <= dlt_val_i;
      if (psc_wr_o)              psc_o    <= psc_val_i;
      if (lock_we_i)             locked_q <= (lock_key_i != UNLOCK_KEY);
    end
  end

  // R9: while locked, configuration holds
  p_locked_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable({reload_o, delta_o, psc_o}));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       stb_i,
  input  logic                       kick_i,
  input  logic [wdog_pkg::KEY_W-1:0] kick_key_i,
  input  logic [CNT_W-1:0]           reload_i,
  input  logic [CNT_W-1:0]           delta_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic                       rst_req_o,
  output logic                       kick_ok_o
);
  import wdog_pkg::*;

  wdog_ev_e ev;

  assign kick_ok_o = kick_i && (kick_key_i == KICK_KEY);

  always_comb begin
    ev = EV_IDLE;
    if (kick_ok_o) begin
      ev = (cnt_o > delta_i) ? EV_EARLY : EV_KICK;
    end else if (stb_i) begin
      ev = (cnt_o == '0) ? EV_UNDER : EV_DEC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o     <= {CNT_W{1'b1}};
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= 1'b0;
      case (ev)
        EV_DEC:            cnt_o <= cnt_o - 1'b1;
        EV_KICK:           cnt_o <= reload_i;
        EV_UNDER, EV_EARLY: begin
          cnt_o     <= reload_i;
          rst_req_o <= 1'b1;
        end
        default:           cnt_o <= cnt_o;
      endcase
    end
  end

  // R2: accepted decrement lowers the count by one
  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i && !kick_ok_o && cnt_o != '0 |=> cnt_o == CNT_W'($past(cnt_o) - 1'b1));
  // R4: decrement at zero raises a reset request
  p_under_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i && !kick_ok_o && cnt_o == '0 |=> rst_req_o);
  // R4: a reset request arrives with the reload value loaded
  p_pulse_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> cnt_o == $past(reload_i));
  // R5: in-window kick gives no reset
  p_inwin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok_o && cnt_o <= delta_i |=> !rst_req_o && cnt_o == $past(reload_i));
  // R6: early kick gives a reset
  p_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok_o && cnt_o > delta_i |=> rst_req_o);
  // R7: wrong key is ignored
  p_badkey_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i && !kick_ok_o && !stb_i |=> $stable(cnt_o) && !rst_req_o);
endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int CNT_W = 12,
  parameter int PSC_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_i,
  input  logic                       dbg_halt_i,
  input  logic                       rld_we_i,
  input  logic [CNT_W-1:0]           rld_val_i,
  input  logic                       dlt_we_i,
  input  logic [CNT_W-1:0]           dlt_val_i,
  input  logic                       psc_we_i,
  input  logic [PSC_W-1:0]           psc_val_i,
  input  logic                       lock_we_i,
  input  logic [wdog_pkg::KEY_W-1:0] lock_key_i,
  input  logic                       kick_i,
  input  logic [wdog_pkg::KEY_W-1:0] kick_key_i,
  output logic [CNT_W-1:0]           count_o,
  output logic                       rst_req_o
);
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] delta;
  logic [PSC_W-1:0] psc;
  logic             psc_wr;
  logic             stb;
  logic             kick_ok;

  wdog_cfg #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .rld_we_i   (rld_we_i),
    .rld_val_i  (rld_val_i),
    .dlt_we_i   (dlt_we_i),
    .dlt_val_i  (dlt_val_i),
    .psc_we_i   (psc_we_i),
    .psc_val_i  (psc_val_i),
    .lock_we_i  (lock_we_i),
    .lock_key_i (lock_key_i),
    .reload_o   (reload),
    .delta_o    (delta),
    .psc_o      (psc),
    .psc_wr_o   (psc_wr)
  );

  wdog_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .halt_i (dbg_halt_i),
    .clr_i  (psc_wr || kick_ok),
    .sel_i  (psc),
    .stb_o  (stb)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb_i      (stb),
    .kick_i     (kick_i),
    .kick_key_i (kick_key_i),
    .reload_i   (reload),
    .delta_i    (delta),
    .cnt_o      (count_o),
    .rst_req_o  (rst_req_o),
    .kick_ok_o  (kick_ok)
  );

  // R8: debug halt freezes the count unless a valid kick arrives
  p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt_i && !kick_ok |=> $stable(count_o) && !rst_req_o);
endmodule

// File: tb/sim_wdog_window.sv
module sim_wdog_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, dbg_halt_i = 1'b0;
  logic        rld_we_i = 1'b0, dlt_we_i = 1'b0, psc_we_i = 1'b0;
  logic        lock_we_i = 1'b0, kick_i = 1'b0;
  logic [11:0] rld_val_i = '0, dlt_val_i = '0;
  logic [2:0]  psc_val_i = '0;
  logic [15:0] lock_key_i = '0, kick_key_i = '0;
  logic [11:0] count_o;
  logic        rst_req_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // behavioural reference state
  int m_cnt, m_rld, m_dlt, m_psc, m_div;
  bit m_lock, m_rst;

  always #4 clk = ~clk;

  wdog_window u0 (.*);

  always @(posedge clk or negedge rst_n) begin
    bit kick_ok, stb;
    if (!rst_n) begin
      m_cnt = 4095; m_rld = 4095; m_dlt = 4095; m_psc = 0; m_div = 0;
      m_lock = 1; m_rst = 0;
    end else begin
      kick_ok = kick_i && kick_key_i == 16'h7E81;
      stb = tick_i && !dbg_halt_i && (m_div == (2 ** m_psc) - 1);
      m_rst = 0;
      if (kick_ok) begin
        if (m_cnt > m_dlt) m_rst = 1;
        m_cnt = m_rld;
      end else if (stb) begin
        if (m_cnt == 0) begin m_rst = 1; m_cnt = m_rld; end
        else m_cnt = m_cnt - 1;
      end
      if ((psc_we_i && !m_lock) || kick_ok || stb) m_div = 0;
      else if (tick_i && !dbg_halt_i) m_div = m_div + 1;
      if (!m_lock) begin
        if (rld_we_i) m_rld = rld_val_i;
        if (dlt_we_i) m_dlt = dlt_val_i;
        if (psc_we_i) m_psc = psc_val_i;
      end
      if (lock_we_i) m_lock = (lock_key_i != 16'hC3A5);
    end
  end

  always @(negedge clk) begin
    cyc++;
    n_chk++;
    if (count_o !== 12'(m_cnt) || rst_req_o !== m_rst) begin
      n_fail++;
      $display("FAIL model cycle %0d: count=%0d rst=%0b expected count=%0d rst=%0b",
               cyc, count_o, rst_req_o, m_cnt, m_rst);
    end
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: run exceeded cycle limit, actual %0d expected <= 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    tick_i = 0; rld_we_i = 0; dlt_we_i = 0; psc_we_i = 0;
    lock_we_i = 0; kick_i = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1;
      step();
    end
  endtask

  task automatic check(string tag, int cnt_exp, bit rst_exp);
    n_chk++;
    if (count_o !== 12'(cnt_exp) || rst_req_o !== rst_exp) begin
      n_fail++;
      $display("FAIL %s: count=%0d rst=%0b expected count=%0d rst=%0b",
               tag, count_o, rst_req_o, cnt_exp, rst_exp);
    end
  endtask

  task automatic kick(logic [15:0] key);
    kick_i = 1; kick_key_i = key;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 4095, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", 4095, 0);

    // locked: write ignored
    rld_we_i = 1; rld_val_i = 12'd30; step();
    kick(16'h7E81);
    check("R9 locked write ignored", 4095, 0);

    lock_we_i = 1; lock_key_i = 16'hC3A5; step();
    rld_we_i = 1; rld_val_i = 12'd20; step();
    check("R10 reload not applied yet", 4095, 0);
    kick(16'h7E81);
    check("R5 kick in window", 20, 0);

    ticks(5);
    check("R2 five decrements", 15, 0);

    kick(16'h1234);
    check("R7 wrong key ignored", 15, 0);

    dlt_we_i = 1; dlt_val_i = 12'd10; step();
    kick(16'h7E81);
    check("R6 early kick resets", 20, 1);
    step();
    check("R6 pulse ends", 20, 0);

    psc_we_i = 1; psc_val_i = 3'd2; step();
    ticks(3);
    check("R3 divide by 4 partial", 20, 0);
    ticks(1);
    check("R3 divide by 4 strobe", 19, 0);
    ticks(4);
    check("R3 divide by 4 second", 18, 0);

    dbg_halt_i = 1;
    ticks(8);
    check("R8 halt freezes", 18, 0);
    dbg_halt_i = 0;

    psc_we_i = 1; psc_val_i = 3'd0; step();
    ticks(18);
    check("R4 reached zero", 0, 0);
    ticks(1);
    check("R4 underflow pulse", 20, 1);
    step();
    check("R4 single cycle pulse", 20, 0);

    ticks(10);
    check("R5 at window edge", 10, 0);
    kick(16'h7E81);
    check("R5 kick at delta", 20, 0);

    lock_we_i = 1; lock_key_i = 16'h1234; step();
    psc_we_i = 1; psc_val_i = 3'd5; step();
    dlt_we_i = 1; dlt_val_i = 12'd0; step();
    ticks(1);
    check("R9 relocked rate kept", 19, 0);
    kick(16'h7E81);
    check("R9 relocked delta kept", 20, 1);

    step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule